// File: doc/BRIEF.md
# Wrapping Fibonacci Sequence Counter

This block is a synchronous counter whose output steps through a short Fibonacci run instead of binary counting. On each clock edge where the count enable is high, the output moves to the next term: 1, 1, 2, 3, 5, 8, 13. After 13 it starts again at the first 1. Each new term is the sum of the two most recent terms. Those two terms are kept in two small history registers.

The value 1 appears twice in a row, so the visible value alone cannot choose the next term. The older history register makes the choice. It holds 0 while the first 1 is shown and 1 while the second 1 is shown. When the output reaches the terminal value 13, the control side reloads the starting history instead of letting the adder run on. This gives the sequence a fixed length. A wrap strobe marks the enabled cycle in which 13 is shown. The value output comes straight from a register, not from the adder.

Top module: `fib_wrap_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next `value` is 1, and this is the first 1 of the sequence. The next two enabled steps then give 1 and then 2.
- R2: With `en` held high and starting from reset, `value` shows 1, 1, 2, 3, 5, 8, 13 on successive clock cycles. Each term from the third on equals the sum of the two terms before it.
- R3: A rising edge with `en` low and `rst` low leaves `value` unchanged, and `wrap` is low for that cycle.
- R4: An enabled edge while `value` is 13 makes `value` 1. The next two enabled edges give 1 and then 2, so the sequence repeats with a period of seven enabled steps.
- R5: `wrap` is high exactly when `en` is high, `rst` is low and `value` is 13. Otherwise it is low.
- R6: A synchronous reset in the middle of the sequence, with `en` high, returns `value` to the first 1. Reset takes priority over both advancing and wrapping.
- R7: `value` is always one of 1, 2, 3, 5, 8, 13. It never takes 0 or any value above 13.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the first term |
| en | input | 1 | Count enable; the sequence advances only when high |
| value | output | 4 | Current Fibonacci term, driven from a register |
| wrap | output | 1 | High in the enabled cycle that shows the terminal term 13 |

## Verification
The assertions assume that `rst` is high at the first clock edge. They also assume that `en` and `rst` are stable, known levels around each rising edge. Nothing assumes that `en` follows any pattern.

The bench meets these assumptions by holding reset from time zero and changing inputs only on falling edges. It drives long runs of enable patterns: always on, sparse, and periodic with gaps. These patterns place hold cycles on both 1 terms and on 13. The bench also pulses reset at several points in the sequence, including while 13 is shown.

// File: rtl/fib_wrap_pkg.sv
package fib_wrap_pkg;

  // Strobes sent from control to datapath each cycle.
  typedef struct packed {
    logic seedLoad;  // reload the starting history
    logic advance;   // shift in the sum of the two history terms
  } fibStrobe_t;

endpackage

// File: rtl/fib_wrap_ctrl.sv
module fib_wrap_ctrl
  import fib_wrap_pkg::*;
#(
  parameter int VAL_W    = 4,
  parameter int TERM_VAL = 13,
  parameter int SEED_CUR = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [VAL_W-1:0] curVal,
  output fibStrobe_t       strobe,
  output logic             wrapOut
);

  localparam logic [VAL_W-1:0] TermCode = VAL_W'(TERM_VAL);
  localparam logic [VAL_W-1:0] SeedCode = VAL_W'(SEED_CUR);

  logic atTerm;

  assign atTerm          = (curVal == TermCode);
  assign strobe.seedLoad = rst | (en & atTerm);
  assign strobe.advance  = en & ~atTerm & ~rst;
  assign wrapOut         = en & atTerm & ~rst;

  // R4: an enabled step taken from the terminal term lands on the seed
  a_r4_reload_after_term: assert property (@(posedge clk) disable iff (rst)
    (en && curVal == TermCode) |=> (curVal == SeedCode));

  // R5: the wrap strobe never shows while reset is applied
  a_r5_no_wrap_in_reset: assert property (@(posedge clk)
    rst |-> !wrapOut);

endmodule

// File: rtl/fib_wrap_datapath.sv
module fib_wrap_datapath
  import fib_wrap_pkg::*;
#(
  parameter int VAL_W     = 4,
  parameter int HIST_W    = 3,
  parameter int SEED_CUR  = 1,
  parameter int SEED_PREV = 0,
  parameter int TERM_VAL  = 13
) (
  input  logic             clk,
  input  fibStrobe_t       strobe,
  input  logic             rst,
  output logic [VAL_W-1:0] curVal
);

  localparam logic [VAL_W-1:0]  SeedCur  = VAL_W'(SEED_CUR);
  localparam logic [HIST_W-1:0] SeedPrev = HIST_W'(SEED_PREV);
  localparam logic [VAL_W-1:0]  TermCode = VAL_W'(TERM_VAL);

  logic [VAL_W-1:0]  curReg;
  logic [HIST_W-1:0] prevReg;
  logic [VAL_W-1:0]  sumTerm;

  // Zero-extend the older term and add it to the newer one.
  assign sumTerm = curReg + {{(VAL_W-HIST_W){1'b0}}, prevReg};

  always_ff @(posedge clk) begin
    if (strobe.seedLoad) begin
      curReg  <= SeedCur;
      prevReg <= SeedPrev;
    end else if (strobe.advance) begin
      curReg  <= sumTerm;
      prevReg <= curReg[HIST_W-1:0];
    end
  end

  assign curVal = curReg;

  // R3: with neither strobe active, the held term stays put
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!strobe.seedLoad && !strobe.advance) |=> $stable(curReg));

  // R7: the term never falls outside 1..terminal
  a_r7_legal_range: assert property (@(posedge clk) disable iff (rst)
    (curReg != '0) && (curReg <= TermCode));

endmodule

// File: rtl/fib_wrap_counter.sv
module fib_wrap_counter
  import fib_wrap_pkg::*;
#(
  parameter int VAL_W     = 4,
  parameter int HIST_W    = 3,
  parameter int SEED_CUR  = 1,
  parameter int SEED_PREV = 0,
  parameter int TERM_VAL  = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [VAL_W-1:0] value,
  output logic             wrap
);

  fibStrobe_t       strobe;
  logic [VAL_W-1:0] curVal;

  fib_wrap_ctrl #(
    .VAL_W   (VAL_W),
    .TERM_VAL(TERM_VAL),
    .SEED_CUR(SEED_CUR)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .curVal (curVal),
    .strobe (strobe),
    .wrapOut(wrap)
  );

  fib_wrap_datapath #(
    .VAL_W    (VAL_W),
    .HIST_W   (HIST_W),
    .SEED_CUR (SEED_CUR),
    .SEED_PREV(SEED_PREV),
    .TERM_VAL (TERM_VAL)
  ) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .rst   (rst),
    .curVal(curVal)
  );

  assign value = curVal;

  // R1 and R6: a reset edge always leaves the seed term on the output
  a_r1_reset_seed: assert property (@(posedge clk)
    rst |=> (value == VAL_W'(SEED_CUR)));

  // R3: a disabled edge outside reset keeps the output steady
  a_r3_port_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(value));

endmodule

// File: tb/fib_wrap_counter_tb.sv
module fib_wrap_counter_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] value;
  logic       wrap;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  // Bench model: the k-th term (k = 0..6) of the run is computed arithmetically.
  int stepIdx = 0;

  fib_wrap_counter u_dut (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .value(value),
    .wrap (wrap)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int fibTerm(input int k);
    int a = 1;
    int b = 1;
    for (int i = 0; i < k; i++) begin
      int t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive inputs at the falling edge, check the outputs, then let the rising edge update the model.
  task automatic step(input bit rstBit, input bit enBit, input string req);
    int expVal;
    bit expWrap;
    @(negedge clk);
    rst = rstBit;
    en  = enBit;
    #1;
    expVal  = fibTerm(stepIdx);
    expWrap = enBit && !rstBit && (expVal == 13);
    check(value == 4'(expVal), req, value, expVal);
    check(wrap == expWrap, "R5", wrap, expWrap);
    check((value inside {4'd1, 4'd2, 4'd3, 4'd5, 4'd8, 4'd13}), "R7", value, expVal);
    @(posedge clk);
    if (rstBit)     stepIdx = 0;
    else if (enBit) stepIdx = (stepIdx + 1) % 7;
  endtask

  initial begin
    // R1: reset applied from time zero, then check the first terms
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b0, 1'b1, "R1");  // first 1
    step(1'b0, 1'b1, "R1");  // second 1
    step(1'b0, 1'b1, "R1");  // 2
    // R2: straight run through several full periods
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, "R2");
    // R3: hold on every term position with gaps of varied length
    for (int i = 0; i < 14; i++) begin
      step(1'b0, 1'b1, "R3");
      for (int g = 0; g <= (i % 3); g++) step(1'b0, 1'b0, "R3");
    end
    // R4: periodic enable patterns sweeping the wrap point
    for (int p = 2; p <= 5; p++)
      for (int i = 0; i < 40; i++) step(1'b0, (i % p) != 0, "R4");
    // R6: mid-sequence reset at each term position, enable high
    for (int pos = 0; pos < 7; pos++) begin
      for (int i = 0; i < pos; i++) step(1'b0, 1'b1, "R6");
      step(1'b1, 1'b1, "R6");
      step(1'b0, 1'b1, "R6");
      step(1'b0, 1'b1, "R6");
      step(1'b0, 1'b1, "R6");
    end
    // Exhaustive-ish pseudo-random enable sweep
    for (int i = 0; i < 300; i++) step(1'b0, ((i * 37 + 11) % 7) > 2, "R2");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule